// File: doc/BRIEF.md
# Four-mode timer / event counter

This block is a 16-bit count register, split into a high byte and a low byte, that advances on count ticks. A tick comes from one of two sources. The internal source is the system clock divided by twelve. The external source is a falling edge on an event pin, which is sampled through two flops. A 2-bit mode field decides how the two bytes behave:

- **Mode 0:** a short count with a 5-bit prescaler.
- **Mode 1:** one full 16-bit up-count.
- **Mode 2:** an 8-bit low-byte count that reloads itself from the high byte.
- **Mode 3:** a frozen state.

Software can write either byte through a shared load port. A rollover sets a sticky overflow flag. It also produces a one-cycle overflow pulse that a serial port can use as its bit-rate tick.

Top module: `evt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, both count bytes, `ovf_flag` and `ovf_pulse` go to 0.
- R2: With `run_en`=1 and `src_ext`=0, exactly one tick occurs every 12 clock cycles. The first tick lands on the 12th rising edge after `run_en` is raised. The divider restarts from zero whenever counting from the internal source stops.
- R3: With `run_en`=1 and `src_ext`=1, one tick occurs for each high-to-low transition of `evt_pin`. That tick acts on the count at the second rising edge after the pin is first seen low. A steady level or a rising transition produces no tick.
- R4: With `run_en`=0, neither byte changes except through a load, and no overflow occurs.
- R5: In mode 0 (`mode`=2'b00), `cnt_lo[4:0]` is a prescaler that advances on each tick. When it passes 31, it wraps to 0 and `cnt_hi` advances. `cnt_lo[7:5]` never changes on a tick. A rollover happens when `cnt_hi`=8'hFF and `cnt_lo[4:0]`=5'h1F on a tick.
- R6: In mode 1 (`mode`=2'b01), `{cnt_hi,cnt_lo}` is a 16-bit up-counter. A tick at 16'hFFFF gives 16'h0000 and an overflow.
- R7: In mode 2 (`mode`=2'b10), only `cnt_lo` counts. A tick at 8'hFF loads `cnt_lo` with `cnt_hi` and signals an overflow. `cnt_hi` is left unchanged by ticks.
- R8: In mode 3 (`mode`=2'b11), ticks leave both bytes unchanged and never signal an overflow.
- R9: `ld_hi_en` and `ld_lo_en` write `ld_data` into the high or low byte at the next rising edge. Any cycle with a load asserted discards that cycle's tick.
- R10: `ovf_pulse` is high for exactly the one cycle that follows the rising edge at which the count rolled over.
- R11: `ovf_flag` is set by a rollover and stays set until `ovf_clr` is high at a rising edge. When a rollover and `ovf_clr` coincide, the flag ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables counting |
| src_ext | input | 1 | 1 = count falling edges of `evt_pin`, 0 = count clock divided by 12 |
| mode | input | 2 | Operating mode, 0 to 3 as in R5 to R8 |
| evt_pin | input | 1 | External event input |
| ld_hi_en | input | 1 | Write `ld_data` into the high byte |
| ld_lo_en | input | 1 | Write `ld_data` into the low byte |
| ld_data | input | 8 | Load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_hi | output | 8 | High count byte |
| cnt_lo | output | 8 | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow pulse, usable as a bit-rate tick |

## Verification
The bound assertions check the following on every cycle:
- the frozen-count rules for mode 3 and for a disabled counter;
- that the high byte stays put in reload mode;
- that the prescaled mode leaves the low byte's top bits untouched;
- load write-through;
- the single-cycle pulse width;
- stickiness of the flag and the clear winning over a set.

The exact tick cadence cannot be expressed as a short property. This covers the divide-by-twelve spacing, the two-flop latency for pin edges, and the wrap points in every mode. The bench's scenarios cover them by comparing a behavioural model against the outputs at every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 5;
    localparam int CLK_DIV = 12;

    typedef enum logic [1:0] {
        MODE_SCALED = 2'd0,
        MODE_WIDE   = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_HOLD   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_s;

    function automatic logic all_ones_byte(input logic [BYTE_W-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/evt_timer_tick.sv
module evt_timer_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic src_ext,
    input  logic evt_pin,
    output logic tick
);
    logic pin_s1, pin_s2;
    logic int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
        end else begin
            pin_s1 <= evt_pin;
            pin_s2 <= pin_s1;
        end
    end

    generate
        if (DIV <= 1) begin : g_nodiv
            assign int_tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            localparam logic [DW-1:0] ONE  = DW'(1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || !run_en || src_ext) div_q <= '0;
                else if (div_q == LAST)         div_q <= '0;
                else                            div_q <= div_q + ONE;
            end
            assign int_tick = (div_q == LAST);
        end
    endgenerate

    always_comb begin
        if (!run_en)     tick = 1'b0;
        else if (src_ext) tick = pin_s2 & ~pin_s1;
        else             tick = int_tick;
    end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  tmr_mode_e         mode,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [BYTE_W-1:0] ld_data,
    output cnt_s              cnt,
    output logic              wrap
);
    localparam logic [BYTE_W-1:0]   ONE_B = BYTE_W'(1);
    localparam logic [PW-1:0]       ONE_P = PW'(1);
    localparam logic [2*BYTE_W-1:0] ONE_W = (2*BYTE_W)'(1);

    cnt_s cur, nxt;

    assign cnt = cur;

    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (ld_hi || ld_lo) begin
            if (ld_hi) nxt.hi = ld_data;
            if (ld_lo) nxt.lo = ld_data;
        end else if (tick) begin
            case (mode)
                MODE_SCALED: begin
                    if (&cur.lo[PW-1:0]) begin
                        nxt.lo[PW-1:0] = '0;
                        nxt.hi         = cur.hi + ONE_B;
                        wrap           = all_ones_byte(cur.hi);
                    end else begin
                        nxt.lo[PW-1:0] = cur.lo[PW-1:0] + ONE_P;
                    end
                end
                MODE_WIDE: begin
                    nxt  = cur + ONE_W;
                    wrap = &cur;
                end
                MODE_RELOAD: begin
                    if (all_ones_byte(cur.lo)) begin
                        nxt.lo = cur.hi;
                        wrap   = 1'b1;
                    end else begin
                        nxt.lo = cur.lo + ONE_B;
                    end
                end
                default: begin
                    nxt = cur;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/evt_timer_flag.sv
module evt_timer_flag (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic clr,
    output logic flag,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= wrap;
            if (clr)       flag <= 1'b0;
            else if (wrap) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int DIV = CLK_DIV,
    parameter int PW  = PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              src_ext,
    input  logic [1:0]        mode,
    input  logic              evt_pin,
    input  logic              ld_hi_en,
    input  logic              ld_lo_en,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              ovf_clr,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic              ovf_flag,
    output logic              ovf_pulse
);
    logic tick, wrap;
    cnt_s cnt;

    evt_timer_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .run_en(run_en), .src_ext(src_ext),
        .evt_pin(evt_pin), .tick(tick)
    );

    evt_timer_core #(.PW(PW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .mode(tmr_mode_e'(mode)),
        .ld_hi(ld_hi_en), .ld_lo(ld_lo_en), .ld_data(ld_data),
        .cnt(cnt), .wrap(wrap)
    );

    evt_timer_flag u_flag (
        .clk(clk), .rst(rst), .wrap(wrap), .clr(ovf_clr),
        .flag(ovf_flag), .pulse(ovf_pulse)
    );

    assign cnt_hi = cnt.hi;
    assign cnt_lo = cnt.lo;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic [1:0] mode,
    input logic       ld_hi_en,
    input logic       ld_lo_en,
    input logic [7:0] ld_data,
    input logic       ovf_clr,
    input logic [7:0] cnt_hi,
    input logic [7:0] cnt_lo,
    input logic       ovf_flag,
    input logic       ovf_pulse
);
    logic no_ld;
    assign no_ld = !ld_hi_en && !ld_lo_en;

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!run_en && no_ld) |=> ($stable(cnt_hi) && $stable(cnt_lo) && !ovf_pulse));

    assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && no_ld) |=> ($stable(cnt_hi) && $stable(cnt_lo) && !ovf_pulse));

    assert_reload_hi_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !ld_hi_en) |=> $stable(cnt_hi));

    assert_scaled_top_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !ld_lo_en) |=> (cnt_lo[7:5] == $past(cnt_lo[7:5])));

    assert_load_lo_R9: assert property (@(posedge clk) disable iff (rst)
        ld_lo_en |=> (cnt_lo == $past(ld_data)));

    assert_load_hi_R9: assert property (@(posedge clk) disable iff (rst)
        ld_hi_en |=> (cnt_hi == $past(ld_data)));

    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
        ovf_clr |=> !ovf_flag);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind evt_timer evt_timer_chk u_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .mode(mode),
    .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en), .ld_data(ld_data),
    .ovf_clr(ovf_clr), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
    .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0, src_ext = 1'b0, evt_pin = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       ld_hi_en = 1'b0, ld_lo_en = 1'b0, ovf_clr = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] cnt_hi, cnt_lo;
    logic       ovf_flag, ovf_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_hi = 0, m_lo = 0, m_div = 0, m_p1 = 0, m_p2 = 0;
    bit m_flag = 0, m_pulse = 0;

    always #10 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst(rst), .run_en(run_en), .src_ext(src_ext), .mode(mode),
        .evt_pin(evt_pin), .ld_hi_en(ld_hi_en), .ld_lo_en(ld_lo_en),
        .ld_data(ld_data), .ovf_clr(ovf_clr), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
    );

    always @(posedge clk) begin
        bit tk, ov;
        int v;
        tk = 0; ov = 0;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_div = 0; m_p1 = 0; m_p2 = 0;
            m_flag = 0; m_pulse = 0;
        end else begin
            if (run_en) begin
                if (src_ext) tk = (m_p2 == 1 && m_p1 == 0);
                else         tk = (m_div == 11);
            end
            if (run_en && !src_ext) m_div = (m_div + 1) % 12;
            else                    m_div = 0;
            m_p2 = m_p1;
            m_p1 = evt_pin;
            if (ld_hi_en || ld_lo_en) begin
                if (ld_hi_en) m_hi = ld_data;
                if (ld_lo_en) m_lo = ld_data;
            end else if (tk) begin
                case (mode)
                    2'd0: begin
                        if (m_lo % 32 == 31) begin
                            m_lo = m_lo - 31;
                            if (m_hi == 255) begin m_hi = 0; ov = 1; end
                            else m_hi = m_hi + 1;
                        end else m_lo = m_lo + 1;
                    end
                    2'd1: begin
                        v = m_hi * 256 + m_lo + 1;
                        if (v == 65536) begin v = 0; ov = 1; end
                        m_hi = v / 256; m_lo = v % 256;
                    end
                    2'd2: begin
                        if (m_lo == 255) begin m_lo = m_hi; ov = 1; end
                        else m_lo = m_lo + 1;
                    end
                    default: ;
                endcase
            end
            m_pulse = ov;
            if (ovf_clr) m_flag = 0;
            else if (ov) m_flag = 1;
        end
        #5;
        if (!done) begin
            n_cmp++;
            if (cnt_hi != m_hi[7:0] || cnt_lo != m_lo[7:0] ||
                ovf_flag != m_flag || ovf_pulse != m_pulse) begin
                n_bad++;
                $display("FAIL %s model: actual hi=%h lo=%h flag=%b pulse=%b expected hi=%h lo=%h flag=%b pulse=%b",
                         tag, cnt_hi, cnt_lo, ovf_flag, ovf_pulse,
                         m_hi[7:0], m_lo[7:0], m_flag, m_pulse);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int hi, input int lo);
        ld_hi_en = 1; ld_data = hi[7:0]; cyc(1);
        ld_hi_en = 0; ld_lo_en = 1; ld_data = lo[7:0]; cyc(1);
        ld_lo_en = 0;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            evt_pin = 1; cyc(1);
            evt_pin = 0; cyc(1);
        end
        cyc(3);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1 hi", cnt_hi, 0); chk("R1 lo", cnt_lo, 0);
        chk("R1 flag", ovf_flag, 0); chk("R1 pulse", ovf_pulse, 0);
        rst = 0; cyc(1);

        // R6 / R2: 16-bit wrap from internal divided clock
        tag = "R6"; mode = 2'b01; src_ext = 0;
        load(8'hFF, 8'hFE);
        run_en = 1; cyc(11);
        chk("R2 no tick before 12", cnt_lo, 8'hFE);
        cyc(1);
        chk("R2 tick at 12", cnt_lo, 8'hFF);
        cyc(12);
        chk("R6 wrap hi", cnt_hi, 0); chk("R6 wrap lo", cnt_lo, 0);
        chk("R10 pulse high", ovf_pulse, 1); chk("R11 flag set", ovf_flag, 1);
        cyc(1);
        chk("R10 pulse one cycle", ovf_pulse, 0); chk("R11 flag sticky", ovf_flag, 1);
        run_en = 0;
        tag = "R11"; ovf_clr = 1; cyc(1); ovf_clr = 0;
        chk("R11 clear", ovf_flag, 0);

        // R4: disabled
        tag = "R4"; cyc(30);
        chk("R4 hold lo", cnt_lo, 0); chk("R4 hold hi", cnt_hi, 0);

        // R7 / R3: reload mode on pin edges
        tag = "R7"; mode = 2'b10; src_ext = 1;
        load(8'hF0, 8'hFE); run_en = 1;
        events(1);
        chk("R3 one edge", cnt_lo, 8'hFF);
        evt_pin = 1; cyc(6);
        chk("R3 level/rise no tick", cnt_lo, 8'hFF);
        evt_pin = 0; cyc(3);
        chk("R7 reload lo", cnt_lo, 8'hF0); chk("R7 hi kept", cnt_hi, 8'hF0);
        chk("R7 flag", ovf_flag, 1);
        ovf_clr = 1; cyc(1); ovf_clr = 0;

        // R5: prescaled mode
        tag = "R5"; mode = 2'b00;
        load(8'hFF, 8'hFE);
        events(1);
        chk("R5 prescale step", cnt_lo, 8'hFF); chk("R5 hi wait", cnt_hi, 8'hFF);
        events(1);
        chk("R5 wrap hi", cnt_hi, 0); chk("R5 upper lo kept", cnt_lo, 8'hE0);
        chk("R5 flag", ovf_flag, 1);
        events(32);
        chk("R5 32 events", cnt_hi, 1); chk("R5 lo after 32", cnt_lo, 8'hE0);
        ovf_clr = 1; cyc(1); ovf_clr = 0;

        // R8: frozen
        tag = "R8"; mode = 2'b11; events(5);
        chk("R8 hi", cnt_hi, 1); chk("R8 lo", cnt_lo, 8'hE0); chk("R8 flag", ovf_flag, 0);

        // R9: load during internal counting discards tick
        tag = "R9"; mode = 2'b01; src_ext = 0;
        run_en = 0; load(8'h00, 8'h00); run_en = 1;
        cyc(11); ld_lo_en = 1; ld_data = 8'h55; cyc(1); ld_lo_en = 0;
        chk("R9 load wins over tick", cnt_lo, 8'h55);
        cyc(12);
        chk("R9 counting resumes", cnt_lo, 8'h56);

        // R11: clear held while reload wraps
        tag = "R11"; run_en = 0; mode = 2'b10; src_ext = 1;
        load(8'h10, 8'hFF); run_en = 1; ovf_clr = 1;
        events(1);
        chk("R11 wrap happened", cnt_lo, 8'h10);
        chk("R11 clear wins", ovf_flag, 0);
        ovf_clr = 0; cyc(2);
        chk("R11 stays clear", ovf_flag, 0);
        run_en = 0; cyc(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule